// File: doc/BRIEF.md
# Two-Pass Lookahead Tree Adder

A purely combinational adder of width N, where N is a power of two (8 by default, 32 or wider by parameter). Each bit position derives a local generate (both operand bits set) and a local propagate (operand bits differ). A balanced binary tree then merges neighbouring groups upward, pair by pair, into one group spanning the whole word. A second tree, the mirror of the first, starts from the carry-in at the root and sends carries down. At every node the lower half receives the node's incoming carry unchanged. The upper half receives a carry when the lower half generates one, or when the lower half propagates the incoming carry.

The depth of both trees grows as log2(N). The tree holds N-1 merged group-and-carry nodes, and no carry ripples from bit to bit. Each sum bit is the bit's propagate XOR the carry that the tree delivers to it. The carry-out is formed from the root group's generate and propagate together with the carry-in.

Top module: `gp_tree_adder`

## Requirements
- R1: `sum` equals the low N bits of `a + b + cin`, taken as unsigned values.
- R2: `cout` equals bit N of the unsigned `a + b + cin`.
- R3: When `b` is zero and `cin` is 0, `sum` equals `a` and `cout` is 0.
- R4: When `a` is the bitwise complement of `b`, a carry-in of 0 gives `sum` all ones and `cout` 0. A carry-in of 1 ripples across every bit, giving `sum` of zero and `cout` of 1.
- R5: With `a` all ones, `b` equal to 1 and `cin` 0, a carry generated at bit 0 reaches the top: `sum` is zero and `cout` is 1.
- R6: The carry delivered to every bit i equals bit i of the sum of the operands' bits below i plus `cin`. Bit 0 receives `cin` itself. As a consequence, the upper half of `sum` equals the upper halves of the operands added to the carry out of the lower halves.
- R7: Exchanging `a` and `b` leaves `sum` and `cout` unchanged.
- R8: The same structure is correct for any power-of-two width; both the 8-bit and the 32-bit builds satisfy R1 and R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of the sum |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
The assertions assume that the operands and the carry-in are settled, known values whenever the combinational checks evaluate. They also assume that N is a power of two, so that the heap-numbered tree is complete. The bench drives inputs only just after a rising clock edge and compares at the falling edge, so every comparison sees a settled combinational path. It instantiates only power-of-two widths: 8 bits, swept over all 2^17 operand and carry combinations, and 32 bits, driven with seeded random vectors plus directed carry-chain patterns.

// File: rtl/gp_tree_adder.sv
module gp_tree_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  localparam int LG    = $clog2(N);
  localparam int NODES = 2 * N;

  // Heap numbering: node 1 is the root, node n has children 2n (low) and
  // 2n+1 (high); leaves N..2N-1 are bits 0..N-1.
  logic [NODES-1:1] gt;
  logic [NODES-1:1] pt;
  logic [NODES-1:1] ct;

  assign gt[NODES-1:N] = a & b;
  assign pt[NODES-1:N] = a ^ b;
  assign ct[1]         = cin;

  for (genvar lvl = 0; lvl < LG; lvl++) begin : g_lvl
    for (genvar j = 0; j < (1 << lvl); j++) begin : g_node
      localparam int ND = (1 << lvl) + j;
      localparam int LO = 2 * ND;
      localparam int HI = 2 * ND + 1;
      assign gt[ND] = gt[HI] | (pt[HI] & gt[LO]);
      assign pt[ND] = pt[HI] & pt[LO];
      assign ct[LO] = ct[ND];
      assign ct[HI] = gt[LO] | (pt[LO] & ct[ND]);
    end
  end

  assign sum  = pt[NODES-1:N] ^ ct[NODES-1:N];
  assign cout = gt[1] | (pt[1] & cin);
endmodule

// File: rtl/gp_tree_adder_chk.sv
module gp_tree_adder_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic         cin,
  input logic [N-1:0] sum,
  input logic         cout,
  input logic [N-1:0] bit_c
);
  logic [N:0] total;
  assign total = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};

  always_comb begin
    p_sum_r1: assert (sum == total[N-1:0]);
    p_cout_r2: assert (cout == total[N]);
    if (b == '0 && !cin) begin
      p_zero_r3: assert (sum == a && !cout);
    end
    if (a == ~b) begin
      p_prop_r4: assert (sum == {N{~cin}} && cout == cin);
    end
    if (a == '1 && b == {{(N-1){1'b0}}, 1'b1} && !cin) begin
      p_gen_r5: assert (sum == '0 && cout);
    end
    p_c0_r6: assert (bit_c[0] == cin);
  end

  for (genvar i = 1; i < N; i++) begin : g_bc
    logic [i:0] low;
    assign low = {1'b0, a[i-1:0]} + {1'b0, b[i-1:0]} + {{i{1'b0}}, cin};
    always_comb begin
      p_bitcarry_r6: assert (bit_c[i] == low[i]);
    end
  end
endmodule

bind gp_tree_adder gp_tree_adder_chk #(.N(N)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .bit_c(ct[2*N-1:N])
);

// File: tb/gp_tree_adder_tb.sv
module gp_tree_adder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0]  a8, b8, s8;
  logic        c8, co8;
  logic [31:0] a32, b32, s32;
  logic        c32, co32;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gp_tree_adder #(.N(8))  u_dut   (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));
  gp_tree_adder #(.N(32)) u_dut_w (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));

  function automatic logic [32:0] ref_add(input logic [31:0] x, input logic [31:0] y,
                                          input logic c, input int w);
    logic [32:0] t;
    logic [32:0] m;
    m = (33'd1 << w) - 33'd1;
    t = {1'b0, x & m[31:0]} + {1'b0, y & m[31:0]} + {32'd0, c};
    return t & ((m << 1) | 33'd1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive8(input logic [7:0] x, input logic [7:0] y, input logic c);
    @(posedge clk);
    a8 = x; b8 = y; c8 = c;
    @(negedge clk);
  endtask

  task automatic drive32(input logic [31:0] x, input logic [31:0] y, input logic c);
    @(posedge clk);
    a32 = x; b32 = y; c32 = c;
    @(negedge clk);
  endtask

  task automatic full32(input string req);
    logic [32:0] e;
    e = ref_add(a32, b32, c32, 32);
    check({co32, s32} == e, req, {31'd0, co32, s32}, {31'd0, e});
  endtask

  initial begin
    logic [32:0] e;
    logic [4:0]  lo;
    logic [32:0] keep;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R3: idle all-zero inputs
    @(negedge clk);
    check(s8 == 8'd0 && !co8, "R3 idle zero", {55'd0, co8, s8}, 64'd0);

    // R1 R2 R6: exhaustive 8-bit sweep
    for (int x = 0; x < (1 << 17); x++) begin
      logic [16:0] v;
      v = x[16:0];
      drive8(v[7:0], v[15:8], v[16]);
      e = ref_add({24'd0, a8}, {24'd0, b8}, c8, 8);
      check(s8 == e[7:0], "R1 sum8", {56'd0, s8}, {56'd0, e[7:0]});
      check(co8 == e[8], "R2 cout8", {63'd0, co8}, {63'd0, e[8]});
      lo = {1'b0, a8[3:0]} + {1'b0, b8[3:0]} + {4'd0, c8};
      check(s8[7:4] == a8[7:4] + b8[7:4] + {3'd0, lo[4]}, "R6 upper half",
            {60'd0, s8[7:4]}, {60'd0, a8[7:4] + b8[7:4] + {3'd0, lo[4]}});
    end

    // R3 R4 R5 directed on 8 bits
    drive8(8'hA5, 8'h00, 1'b0);
    check(s8 == 8'hA5 && !co8, "R3 b zero", {55'd0, co8, s8}, 64'hA5);
    drive8(8'h3C, 8'hC3, 1'b0);
    check(s8 == 8'hFF && !co8, "R4 propagate cin0", {55'd0, co8, s8}, 64'hFF);
    drive8(8'h3C, 8'hC3, 1'b1);
    check(s8 == 8'h00 && co8, "R4 propagate cin1", {55'd0, co8, s8}, 64'h100);
    drive8(8'hFF, 8'h01, 1'b0);
    check(s8 == 8'h00 && co8, "R5 generate at bit0", {55'd0, co8, s8}, 64'h100);

    // R4 R5 R3 directed on 32 bits
    drive32(32'h0F0F_1234, 32'hF0F0_EDCB, 1'b1);
    check(s32 == 32'd0 && co32, "R4 propagate32", {31'd0, co32, s32}, 64'h1_0000_0000);
    drive32(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    check(s32 == 32'd0 && co32, "R5 generate32", {31'd0, co32, s32}, 64'h1_0000_0000);
    drive32(32'hDEAD_BEEF, 32'h0, 1'b0);
    check(s32 == 32'hDEAD_BEEF && !co32, "R3 b zero32", {31'd0, co32, s32}, 64'hDEAD_BEEF);
    drive32(32'h0000_FFFF, 32'h0000_0001, 1'b0);
    check(s32 == 32'h0001_0000 && !co32, "R6 carry into upper half", {31'd0, co32, s32},
          64'h1_0000);

    // R8 R1 R2 R7: seeded random 32-bit vectors
    void'($urandom(32'd4242));
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] x, y;
      logic        c;
      x = $urandom(); y = $urandom(); c = 1'($urandom());
      if (k % 5 == 0) y = ~x;
      if (k % 7 == 0) x = 32'hFFFF_FFFF;
      drive32(x, y, c);
      full32("R8 R1 R2 sum32");
      keep = {co32, s32};
      drive32(y, x, c);
      check({co32, s32} == keep, "R7 swap operands", {31'd0, co32, s32}, {31'd0, keep});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule